// File: doc/BRIEF.md
# Counted Loop and Relative Branch Next-Pointer Unit

This block works out the next instruction pointer for three kinds of instruction: a plain sequential instruction, an unconditional short relative jump and a counted loop. On each cycle it takes the pointer of the current instruction, that instruction's length in bytes, a signed 8-bit displacement, a 2-bit operation code and the value of the 32-bit count register. One clock later it presents the next pointer, the new count value, a write enable for the count register and a flag that says whether control left the sequential path.

A branch destination is measured from the instruction that follows the branch, not from the branch itself, and all pointer arithmetic wraps modulo 2^32. The counted loop decrements the count first and tests it afterwards. A loop that starts with a count of zero therefore wraps to all ones and keeps branching: its body runs 2^32 times. The unconditional jump always branches and leaves the count register alone. Neither operation reads or writes any status flag.

Top module: `loop_branch_unit`

## Requirements
- R1: While reset is low, and on the first edge after it, nxt_ip, cnt_out and taken are all zero and cnt_we is 0.
- R2: For op_sel 2'b00 (sequential) and 2'b11 (reserved), nxt_ip equals cur_ip + ins_len modulo 2^32, taken is 0 and cnt_we is 0.
- R3: The branch destination equals cur_ip + ins_len + the sign-extended rel_ofs, modulo 2^32.
- R4: For op_sel 2'b01 (jump), nxt_ip is the branch destination, taken is 1, cnt_we is 0 and cnt_out equals cnt_in unchanged.
- R5: For op_sel 2'b10 (loop), cnt_out equals cnt_in - 1 modulo 2^32 and cnt_we is 1.
- R6: For a loop, taken is 1 and nxt_ip is the branch destination when the decremented count is nonzero. Otherwise taken is 0 and nxt_ip is cur_ip + ins_len.
- R7: A loop given cnt_in = 0 returns cnt_out = 32'hFFFF_FFFF and branches. A loop given cnt_in = 1 returns 0 and falls through.
- R8: rel_ofs 8'h80 reaches 128 bytes back and 8'h7F reaches 127 bytes forward from the following instruction. A 2-byte loop at 32'h0C with rel_ofs 8'hFC branches to 32'h0A.
- R9: Every output reflects the inputs sampled on the previous rising clock edge, with exactly one cycle of latency.
- R10: cnt_we is 1 only for the loop operation. A loop sequence that starts at count N runs its body exactly N times for N >= 1, and then leaves the pointer after the loop instruction with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_ip | input | 32 | Pointer of the current instruction |
| ins_len | input | 4 | Length of the current instruction in bytes |
| rel_ofs | input | 8 | Signed displacement from the following instruction |
| op_sel | input | 2 | 00 sequential, 01 jump, 10 loop, 11 reserved (sequential) |
| cnt_in | input | 32 | Current count register value |
| nxt_ip | output | 32 | Next instruction pointer |
| cnt_out | output | 32 | Count value to write back |
| cnt_we | output | 1 | Count register write enable |
| taken | output | 1 | Control left the sequential path |

## Verification
Every one of the 256 displacements is driven for the jump at several pointers, including pointers close to 0 and to 2^32. This separates correct sign extension and correct wrap from a zero-extended displacement, and from a destination measured from the branch itself. Loops are driven with counts of 0, 1, 2, a mid-range value and all ones. These values tell a pre-decrement test from a post-decrement test, and they expose a missing wrap. Short loop programs with counts 1, 3 and 7 are also run, with the count fed back through cnt_we. They confirm the number of times the body runs and the final pointer and count.

// File: rtl/lp_pkg.sv
package lp_pkg;
   typedef enum logic [1:0] {
      LP_SEQ  = 2'b00,
      LP_JMP  = 2'b01,
      LP_LOOP = 2'b10,
      LP_RSV  = 2'b11
   } lp_op_e;
endpackage

// File: rtl/lp_tgt_calc.sv
module lp_tgt_calc #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 8,
   parameter int LEN_W  = 4
) (
   input  logic [ADDR_W-1:0] cur_ip,
   input  logic [LEN_W-1:0]  ins_len,
   input  logic [OFS_W-1:0]  rel_ofs,
   output logic [ADDR_W-1:0] fall_ip,
   output logic [ADDR_W-1:0] tgt_ip
);
   localparam int EXT_W = ADDR_W - OFS_W;
   localparam int LPAD  = ADDR_W - LEN_W;

   logic [ADDR_W-1:0] ofs_ext;
   logic [ADDR_W-1:0] len_ext;

   if (OFS_W > ADDR_W) begin : g_bad_ofs
      $error("lp_tgt_calc: OFS_W must not exceed ADDR_W");
   end
   if (LEN_W >= ADDR_W) begin : g_bad_len
      $error("lp_tgt_calc: LEN_W must be below ADDR_W");
   end

   if (EXT_W > 0) begin : g_sext
      assign ofs_ext = {{EXT_W{rel_ofs[OFS_W-1]}}, rel_ofs};
   end else begin : g_full
      assign ofs_ext = rel_ofs[ADDR_W-1:0];
   end

   assign len_ext = {{LPAD{1'b0}}, ins_len};

   always_comb begin
      fall_ip = cur_ip + len_ext;
      tgt_ip  = fall_ip + ofs_ext;
   end
endmodule

// File: rtl/lp_cnt_dec.sv
module lp_cnt_dec #(
   parameter int CNT_W = 32
) (
   input  logic [CNT_W-1:0] cnt_in,
   output logic [CNT_W-1:0] cnt_dec,
   output logic             dec_nz
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("lp_cnt_dec: CNT_W must be at least 2");
   end

   always_comb begin
      cnt_dec = cnt_in - ONE;
      dec_nz  = |cnt_dec;
   end
endmodule

// File: rtl/lp_nip_sel.sv
module lp_nip_sel
   import lp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input  lp_op_e            op,
   input  logic [ADDR_W-1:0] fall_ip,
   input  logic [ADDR_W-1:0] tgt_ip,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic [CNT_W-1:0]  cnt_dec,
   input  logic              dec_nz,
   output logic [ADDR_W-1:0] nip,
   output logic [CNT_W-1:0]  cnt_nx,
   output logic              we_nx,
   output logic              take_nx
);
   always_comb begin
      nip     = fall_ip;
      cnt_nx  = cnt_in;
      we_nx   = 1'b0;
      take_nx = 1'b0;
      unique case (op)
         LP_JMP: begin
            nip     = tgt_ip;
            take_nx = 1'b1;
         end
         LP_LOOP: begin
            cnt_nx  = cnt_dec;
            we_nx   = 1'b1;
            take_nx = dec_nz;
            nip     = dec_nz ? tgt_ip : fall_ip;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
   import lp_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 32,
   parameter int OFS_W   = 8,
   parameter int LEN_W   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cur_ip,
   input  logic [LEN_W-1:0]  ins_len,
   input  logic [OFS_W-1:0]  rel_ofs,
   input  logic [1:0]        op_sel,
   input  logic [CNT_W-1:0]  cnt_in,
   output logic [ADDR_W-1:0] nxt_ip,
   output logic [CNT_W-1:0]  cnt_out,
   output logic              cnt_we,
   output logic              taken
);
   logic [ADDR_W-1:0] fall_ip, tgt_ip, nip;
   logic [CNT_W-1:0]  cnt_dec, cnt_nx;
   logic              dec_nz, we_nx, take_nx;
   lp_op_e            op;

   assign op = lp_op_e'(op_sel);

   lp_tgt_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_tgt (
      .cur_ip (cur_ip),
      .ins_len(ins_len),
      .rel_ofs(rel_ofs),
      .fall_ip(fall_ip),
      .tgt_ip (tgt_ip)
   );

   lp_cnt_dec #(.CNT_W(CNT_W)) u_dec (
      .cnt_in (cnt_in),
      .cnt_dec(cnt_dec),
      .dec_nz (dec_nz)
   );

   lp_nip_sel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_sel (
      .op     (op),
      .fall_ip(fall_ip),
      .tgt_ip (tgt_ip),
      .cnt_in (cnt_in),
      .cnt_dec(cnt_dec),
      .dec_nz (dec_nz),
      .nip    (nip),
      .cnt_nx (cnt_nx),
      .we_nx  (we_nx),
      .take_nx(take_nx)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            nxt_ip  <= '0;
            cnt_out <= '0;
            cnt_we  <= 1'b0;
            taken   <= 1'b0;
         end else begin
            nxt_ip  <= nip;
            cnt_out <= cnt_nx;
            cnt_we  <= we_nx;
            taken   <= take_nx;
         end
      end
   end else begin : g_comb
      assign nxt_ip  = nip;
      assign cnt_out = cnt_nx;
      assign cnt_we  = we_nx;
      assign taken   = take_nx;
   end
endmodule

// File: rtl/loop_branch_unit_chk.sv
module loop_branch_unit_chk #(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 32,
   parameter int OFS_W   = 8,
   parameter int LEN_W   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cur_ip,
   input logic [LEN_W-1:0]  ins_len,
   input logic [OFS_W-1:0]  rel_ofs,
   input logic [1:0]        op_sel,
   input logic [CNT_W-1:0]  cnt_in,
   input logic [ADDR_W-1:0] nxt_ip,
   input logic [CNT_W-1:0]  cnt_out,
   input logic              cnt_we,
   input logic              taken
);
   localparam int PAD = ADDR_W - LEN_W;
   logic [ADDR_W-1:0] seq_ip;
   assign seq_ip = cur_ip + {{PAD{1'b0}}, ins_len};

   if (OUT_REG) begin : g_chk
      // R1: nothing pending while in reset
      a_r1_reset_idle: assert property (@(posedge clk)
         !$past(rst_n) |-> (!cnt_we && !taken && nxt_ip == '0 && cnt_out == '0));

      // R2 / R9: sequential path one cycle later
      a_r2_seq_next: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && ($past(op_sel) == 2'b00 || $past(op_sel) == 2'b11))
         |-> (nxt_ip == $past(seq_ip) && !taken && !cnt_we));

      // R4: jump keeps the count and always branches
      a_r4_jmp_keeps_cnt: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_sel) == 2'b01)
         |-> (!cnt_we && taken && cnt_out == $past(cnt_in)));

      // R5: loop writes the decremented count
      a_r5_loop_dec: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_sel) == 2'b10)
         |-> (cnt_we && cnt_out == $past(cnt_in) - 1'b1));

      // R6: loop branches exactly when the new count is nonzero
      a_r6_loop_test: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_sel) == 2'b10)
         |-> (taken == (cnt_out != '0)));

      // R6: a loop that falls through goes to the following instruction
      a_r6_loop_fall: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_sel) == 2'b10 && !taken)
         |-> (nxt_ip == $past(seq_ip)));

      // R10: only the loop writes the count
      a_r10_we_only_loop: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && cnt_we) |-> ($past(op_sel) == 2'b10));
   end
endmodule

bind loop_branch_unit loop_branch_unit_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFS_W(OFS_W), .LEN_W(LEN_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cur_ip(cur_ip), .ins_len(ins_len),
   .rel_ofs(rel_ofs), .op_sel(op_sel), .cnt_in(cnt_in), .nxt_ip(nxt_ip),
   .cnt_out(cnt_out), .cnt_we(cnt_we), .taken(taken)
);

// File: tb/loop_branch_unit_tb_top.sv
`timescale 1ns/1ps
module loop_branch_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cur_ip = '0;
   logic [3:0]  ins_len = '0;
   logic [7:0]  rel_ofs = '0;
   logic [1:0]  op_sel = '0;
   logic [31:0] cnt_in = '0;
   logic [31:0] nxt_ip, cnt_out;
   logic        cnt_we, taken;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   loop_branch_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cur_ip(cur_ip), .ins_len(ins_len),
      .rel_ofs(rel_ofs), .op_sel(op_sel), .cnt_in(cnt_in),
      .nxt_ip(nxt_ip), .cnt_out(cnt_out), .cnt_we(cnt_we), .taken(taken)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_tgt(input logic [31:0] ip, input logic [3:0] len,
                                           input logic [7:0] ofs);
      int signed s;
      s = int'($signed(ofs));
      return ip + 32'(len) + 32'(s);
   endfunction

   // drive after a falling edge, registered at the rising edge, sample at next falling edge
   task automatic step(input logic [1:0] op, input logic [31:0] ip, input logic [3:0] len,
                       input logic [7:0] ofs, input logic [31:0] cnt);
      op_sel = op; cur_ip = ip; ins_len = len; rel_ofs = ofs; cnt_in = cnt;
      @(negedge clk);
   endtask

   task automatic run_loop(input logic [31:0] n);
      logic [31:0] ip, cnt;
      int body;
      ip = 32'h0A; cnt = n; body = 0;
      for (int g = 0; g < 64; g++) begin
         if (ip == 32'h0A) begin
            body++;
            step(2'b00, ip, 4'd2, 8'h00, cnt);
            ip = nxt_ip;
         end else if (ip == 32'h0C) begin
            step(2'b10, ip, 4'd2, 8'hFC, cnt);
            if (cnt_we) cnt = cnt_out;
            ip = nxt_ip;
         end else begin
            break;
         end
      end
      chk(body == int'(n), "R10 body count", 32'(body), n);
      chk(ip == 32'h0E, "R10 exit pointer", ip, 32'h0E);
      chk(cnt == 32'h0, "R10 exit count", cnt, 32'h0);
   endtask

   initial begin
      logic [31:0] ips[4];
      logic [31:0] cnts[5];
      logic [31:0] e;
      ips  = '{32'h0000_000C, 32'h0000_0000, 32'hFFFF_FFF0, 32'h1234_5678};
      cnts = '{32'h0, 32'h1, 32'h2, 32'h8000_0000, 32'hFFFF_FFFF};

      op_sel = 2'b10; cnt_in = 32'h5; cur_ip = 32'h40; ins_len = 4'd2;
      repeat (3) @(negedge clk);
      // R1: outputs held idle in reset
      chk(nxt_ip == 0 && cnt_out == 0 && !cnt_we && !taken, "R1 reset state",
          {cnt_we, taken, nxt_ip[29:0]}, 32'h0);
      rst_n = 1'b1;

      // R2: sequential and reserved codes
      for (int k = 0; k < 16; k++) begin
         e = ips[k % 4] + 32'(k);
         step((k % 2) ? 2'b11 : 2'b00, ips[k % 4], 4'(k), 8'h80, 32'h55);
         chk(nxt_ip == e && !taken && !cnt_we, "R2 sequential next", nxt_ip, e);
      end

      // R3 / R4: every displacement for the jump
      foreach (ips[i]) begin
         for (int o = 0; o < 256; o++) begin
            e = ref_tgt(ips[i], 4'd2, 8'(o));
            step(2'b01, ips[i], 4'd2, 8'(o), 32'hA5A5_0000 + 32'(o));
            chk(nxt_ip == e, "R3 jump destination", nxt_ip, e);
            chk(taken && !cnt_we && cnt_out == 32'hA5A5_0000 + 32'(o),
                "R4 jump leaves count", cnt_out, 32'hA5A5_0000 + 32'(o));
         end
      end

      // R5 / R6 / R7: loop with assorted counts and displacements
      foreach (cnts[c]) begin
         for (int o = 0; o < 256; o += 17) begin
            logic [31:0] dc;
            dc = cnts[c] - 32'h1;
            e  = (dc != 0) ? ref_tgt(32'h100, 4'd2, 8'(o)) : 32'h102;
            step(2'b10, 32'h100, 4'd2, 8'(o), cnts[c]);
            chk(cnt_out == dc && cnt_we, "R5 loop decrement", cnt_out, dc);
            chk(nxt_ip == e && taken == (dc != 0), "R6 loop next", nxt_ip, e);
         end
      end
      step(2'b10, 32'h200, 4'd2, 8'h10, 32'h0);
      chk(cnt_out == 32'hFFFF_FFFF && taken, "R7 zero count wraps", cnt_out, 32'hFFFF_FFFF);
      step(2'b10, 32'h200, 4'd2, 8'h10, 32'h1);
      chk(cnt_out == 32'h0 && !taken && nxt_ip == 32'h202, "R7 count one exits",
          nxt_ip, 32'h202);

      // R8: reach limits and the worked case
      step(2'b01, 32'h1000, 4'd2, 8'h80, 32'h0);
      chk(nxt_ip == 32'h1002 - 32'd128, "R8 back reach", nxt_ip, 32'h1002 - 32'd128);
      step(2'b01, 32'h1000, 4'd2, 8'h7F, 32'h0);
      chk(nxt_ip == 32'h1002 + 32'd127, "R8 forward reach", nxt_ip, 32'h1002 + 32'd127);
      step(2'b10, 32'h0C, 4'd2, 8'hFC, 32'h9);
      chk(nxt_ip == 32'h0A, "R8 short loop back", nxt_ip, 32'h0A);

      // R9: output follows the previous edge only
      op_sel = 2'b01; cur_ip = 32'h300; ins_len = 4'd3; rel_ofs = 8'h05;
      @(posedge clk); #1;
      op_sel = 2'b00; cur_ip = 32'h777;
      chk(nxt_ip == 32'h308, "R9 one cycle latency", nxt_ip, 32'h308);
      @(negedge clk);

      // R10: loop programs with fed-back count
      run_loop(32'd1);
      run_loop(32'd3);
      run_loop(32'd7);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule